// File: doc/BRIEF.md
# Bus Timeout Timer Set

This block holds three independent timeout timers for a bus interface controller, plus a DMA watchdog. The three timers cover the handshake-to-handshake gap, selection/reselection, and a general purpose interval. Each timer takes a 4-bit code. Code 0 switches the timer off. Code c of 1 or more sets a timeout of 2^(c-1) base ticks, and one base tick is 100 microseconds. A free-running prescaler makes the base tick by dividing the clock by `CLK_HZ / TICK_HZ`.

A timer restarts on its own restart pulse, or when its code field is written. When a timer expires it sets a sticky status bit. The status bits share one interrupt line, which is gated by a per-timer enable. The watchdog counts in units of 16 clocks from an 8-bit reload value. It restarts on every data transfer pulse and gives a one-cycle pulse when it runs out. Register decoding and the bus events that cause restarts are outside this block; they arrive as plain write strobes and pulses.

Top module: `bus_timeout_timers`

## Requirements
- R1: A timer with code c (1 to 15) sets its status bit between (2^(c-1)-1)*T+2 and 2^(c-1)*T+1 clock edges after the edge that sampled its restart, where T = CLK_HZ/TICK_HZ clocks is the base tick.
- R2: A timer whose code is 0 never expires, even after a restart.
- R3: A strobe on `tctl0_we` loads the handshake code from `wdata[7:4]` and the selection code from `wdata[3:0]`. A strobe on `tctl1_we` loads the general purpose code from `wdata[3:0]`, and `wdata[7:4]` is ignored.
- R4: In `status`, `irq_en` and `restart`, bit 2 is the selection timer, bit 1 is the general purpose timer and bit 0 is the handshake timer.
- R5: Status bits are sticky. A `stat_rd` pulse clears all of them at the next edge. An expiry in that same cycle still sets its bit.
- R6: `irq` is high exactly when some status bit is set and its `irq_en` bit is also set. It follows `irq_en` within the same cycle.
- R7: A restart pulse reloads that timer's full timeout. A write of a timer's code field also restarts that timer.
- R8: After a `wdt_we` write of N (N not 0), or after an `xfer_pulse` with reload N, `wdt_fire` is high for exactly one cycle, 16*N edges after the restarting edge. The watchdog then stays idle until it is restarted again.
- R9: A reload value of 0 disables the watchdog. Each `xfer_pulse` restarts the count, so pulses spaced closer than 16*N clocks keep `wdt_fire` low.
- R10: After reset, `status`, `irq` and `wdt_fire` are 0 and every timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tctl0_we | input | 1 | Write strobe for the handshake and selection codes |
| tctl1_we | input | 1 | Write strobe for the general purpose code |
| wdt_we | input | 1 | Write strobe for the watchdog reload value |
| wdata | input | 8 | Write data shared by the three strobes |
| restart | input | 3 | Per-timer restart pulses (bit 2 sel, 1 gen, 0 hth) |
| xfer_pulse | input | 1 | Data transfer event; restarts the watchdog |
| stat_rd | input | 1 | Status read; clears the sticky status bits |
| irq_en | input | 3 | Per-timer interrupt enables |
| status | output | 3 | Sticky expiry status |
| irq | output | 1 | Combined interrupt request |
| wdt_fire | output | 1 | One-cycle watchdog expiry pulse |

## Verification
The base tick free-runs, so a timer's expiry can fall anywhere within one tick period. The bench therefore checks each timer twice. It checks that the status bit is still clear (2^(c-1)-1)*T edges after the restarting edge, and that it is set 2^(c-1)*T+1 edges after. These two bounds cover the tick register and the status register. The watchdog keeps its own 16-clock sub-count, so its pulse is due at exactly 16*N edges. The bench samples one edge before, at, and one edge after that point. `irq` and the effect of `stat_rd` are due within the same cycle and one edge later, respectively. Inputs are driven, and outputs sampled, 1 ns after a rising edge.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
    localparam int CODE_W = 4;
    localparam int NUM_CH = 3;
    localparam int CNT_W  = (1 << CODE_W) - 1;
    localparam int CH_HTH = 0;
    localparam int CH_GEN = 1;
    localparam int CH_SEL = 2;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  tcnt_t;

    typedef struct packed {
        logic  run;
        tcnt_t cnt;
    } chan_state_t;

    // Number of base ticks for a code; 0 means disabled.
    function automatic tcnt_t code_to_ticks(code_t c);
        tcnt_t one;
        one = tcnt_t'(1);
        if (c == '0)
            return '0;
        return one << (c - code_t'(1));
    endfunction
endpackage

// File: rtl/tmo_prescale.sv
module tmo_prescale #(
    parameter int TICK_CYC = 25000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;

    logic [PW-1:0] pcnt;

    assign tick = (pcnt == PW'(TICK_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + PW'(1);
    end
endmodule

// File: rtl/tmo_chan.sv
module tmo_chan
    import tmo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  restart,
    input  code_t code,
    output logic  expire
);
    chan_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (restart) begin
                st.cnt <= code_to_ticks(code);
                st.run <= (code != '0);
            end else if (st.run && tick) begin
                if (st.cnt == tcnt_t'(1)) begin
                    st.run <= 1'b0;
                    expire <= 1'b1;
                end
                st.cnt <= st.cnt - tcnt_t'(1);
            end
        end
    end
endmodule

// File: rtl/tmo_wdog.sv
module tmo_wdog #(
    parameter int RELOAD_W = 8,
    parameter int UNIT     = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_we,
    input  logic [RELOAD_W-1:0] load_val,
    input  logic                restart,
    output logic                fire
);
    localparam int SW = $clog2(UNIT);

    logic [RELOAD_W-1:0] reload;
    logic [RELOAD_W-1:0] units;
    logic [SW-1:0]       sub;
    logic                run;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '0;
            units  <= '0;
            sub    <= '0;
            run    <= 1'b0;
            fire   <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (load_we) begin
                reload <= load_val;
                units  <= load_val;
                sub    <= '0;
                run    <= (load_val != '0);
            end else if (restart) begin
                units <= reload;
                sub   <= '0;
                run   <= (reload != '0);
            end else if (run) begin
                sub <= sub + SW'(1);
                if (sub == SW'(UNIT - 1)) begin
                    if (units == RELOAD_W'(1)) begin
                        run  <= 1'b0;
                        fire <= 1'b1;
                    end
                    units <= units - RELOAD_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/bus_timeout_timers.sv
module bus_timeout_timers
    import tmo_pkg::*;
#(
    parameter int CLK_HZ   = 250_000_000,
    parameter int TICK_HZ  = 10_000,
    parameter int WDT_W    = 8,
    parameter int WDT_UNIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tctl0_we,
    input  logic              tctl1_we,
    input  logic              wdt_we,
    input  logic [7:0]        wdata,
    input  logic [NUM_CH-1:0] restart,
    input  logic              xfer_pulse,
    input  logic              stat_rd,
    input  logic [NUM_CH-1:0] irq_en,
    output logic [NUM_CH-1:0] status,
    output logic              irq,
    output logic              wdt_fire
);
    localparam int TICK_CYC = CLK_HZ / TICK_HZ;

    code_t [NUM_CH-1:0] codes;
    code_t [NUM_CH-1:0] code_nxt;
    logic  [NUM_CH-1:0] restart_eff;
    logic  [NUM_CH-1:0] chan_exp;
    logic               tick;

    always_comb begin
        code_nxt    = codes;
        restart_eff = restart;
        if (tctl0_we) begin
            code_nxt[CH_HTH]    = wdata[7:4];
            code_nxt[CH_SEL]    = wdata[3:0];
            restart_eff[CH_HTH] = 1'b1;
            restart_eff[CH_SEL] = 1'b1;
        end
        if (tctl1_we) begin
            code_nxt[CH_GEN]    = wdata[3:0];
            restart_eff[CH_GEN] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            codes  <= '0;
            status <= '0;
        end else begin
            codes  <= code_nxt;
            status <= (stat_rd ? '0 : status) | chan_exp;
        end
    end

    assign irq = |(status & irq_en);

    tmo_prescale #(.TICK_CYC(TICK_CYC)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        tmo_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .restart (restart_eff[g]),
            .code    (code_nxt[g]),
            .expire  (chan_exp[g])
        );
    end

    tmo_wdog #(.RELOAD_W(WDT_W), .UNIT(WDT_UNIT)) u_wdog (
        .clk      (clk),
        .rst      (rst),
        .load_we  (wdt_we),
        .load_val (wdata[WDT_W-1:0]),
        .restart  (xfer_pulse),
        .fire     (wdt_fire)
    );
endmodule

// File: rtl/bus_timeout_timers_chk.sv
module bus_timeout_timers_chk #(
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           stat_rd,
    input logic           wdt_we,
    input logic [7:0]     wdata,
    input logic           xfer_pulse,
    input logic [NCH-1:0] status,
    input logic [NCH-1:0] exp_v,
    input logic           wdt_fire
);
    // R5
    status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> ((status & $past(status)) == $past(status)));

    // R5
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && exp_v == '0) |=> (status == '0));

    // R8
    wdt_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_fire |=> !wdt_fire);

    // R9
    wdt_zero_off_chk: assert property (@(posedge clk) disable iff (rst)
        (wdt_we && wdata == 8'h00) |=> !wdt_fire);

    // R9
    wdt_restart_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_pulse |=> !wdt_fire);
endmodule

bind bus_timeout_timers bus_timeout_timers_chk #(.NCH(3)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stat_rd    (stat_rd),
    .wdt_we     (wdt_we),
    .wdata      (wdata),
    .xfer_pulse (xfer_pulse),
    .status     (status),
    .exp_v      (chan_exp),
    .wdt_fire   (wdt_fire)
);

// File: tb/tb_bus_timeout_timers.sv
`timescale 1ns/1ps
module tb_bus_timeout_timers;
    localparam int CLK_HZ  = 80_000;
    localparam int TICK_HZ = 10_000;
    localparam int P       = CLK_HZ / TICK_HZ;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tctl0_we = 1'b0, tctl1_we = 1'b0, wdt_we = 1'b0;
    logic [7:0] wdata = '0;
    logic [2:0] restart = '0;
    logic       xfer_pulse = 1'b0, stat_rd = 1'b0;
    logic [2:0] irq_en = '0;
    logic [2:0] status;
    logic       irq, wdt_fire;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_timeout_timers #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) dut (
        .clk(clk), .rst(rst), .tctl0_we(tctl0_we), .tctl1_we(tctl1_we),
        .wdt_we(wdt_we), .wdata(wdata), .restart(restart),
        .xfer_pulse(xfer_pulse), .stat_rd(stat_rd), .irq_en(irq_en),
        .status(status), .irq(irq), .wdt_fire(wdt_fire)
    );

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_status();
        stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk(status, 3'b000, "R10 status after reset");
        chk(irq, 1'b0, "R10 irq after reset");
        chk(wdt_fire, 1'b0, "R10 wdt_fire after reset");
    endtask

    task automatic t_hth();
        // hth code 3 -> 4 ticks; sel code 0 -> off
        wdata = 8'h30; tctl0_we = 1'b1; cyc(1); tctl0_we = 1'b0;
        cyc(3 * P);
        chk(status, 3'b000, "R1 hth not early");
        cyc(P + 1);
        chk(status, 3'b001, "R1 R3 R4 hth expired bit0");
        chk(irq, 1'b0, "R6 irq masked");
        irq_en = 3'b110; #0.5;
        chk(irq, 1'b0, "R6 irq other enables");
        irq_en = 3'b001; #0.5;
        chk(irq, 1'b1, "R6 irq enabled");
        cyc(200);
        chk(status, 3'b001, "R2 R5 sel code 0 silent, hth sticky");
        clear_status();
        chk(status, 3'b000, "R5 cleared on read");
        chk(irq, 1'b0, "R6 irq drops after clear");
        irq_en = 3'b000;
    endtask

    task automatic t_sel();
        wdata = 8'h02; tctl0_we = 1'b1; cyc(1); tctl0_we = 1'b0;
        cyc(P);
        chk(status, 3'b000, "R1 sel not early");
        cyc(P + 1);
        chk(status, 3'b100, "R1 R3 R4 sel expired bit2");
        clear_status();
    endtask

    task automatic t_gen();
        wdata = 8'hF1; tctl1_we = 1'b1; cyc(1); tctl1_we = 1'b0;
        cyc(P + 1);
        chk(status, 3'b010, "R3 R4 gen code1 expired bit1, upper ignored");
        clear_status();
        restart = 3'b001; cyc(1); restart = 3'b000;
        cyc(100);
        chk(status, 3'b000, "R2 hth code 0 restart no expiry");
    endtask

    task automatic t_restart();
        wdata = 8'h03; tctl1_we = 1'b1; cyc(1); tctl1_we = 1'b0;
        for (int i = 0; i < 4; i++) begin
            cyc(19);
            restart = 3'b010; cyc(1); restart = 3'b000;
        end
        cyc(3 * P);
        chk(status, 3'b000, "R7 restart pulses hold off gen");
        cyc(P + 1);
        chk(status, 3'b010, "R7 gen expires after last restart");
        clear_status();
    endtask

    task automatic t_wdt();
        bit seen;
        wdata = 8'd3; wdt_we = 1'b1; cyc(1); wdt_we = 1'b0;
        cyc(47);
        chk(wdt_fire, 1'b0, "R8 wdt not early");
        cyc(1);
        chk(wdt_fire, 1'b1, "R8 wdt fires at 16*N");
        cyc(1);
        chk(wdt_fire, 1'b0, "R8 wdt pulse one cycle");
        seen = 1'b0;
        for (int i = 0; i < 100; i++) begin
            cyc(1);
            if (wdt_fire) seen = 1'b1;
        end
        chk(seen, 1'b0, "R8 wdt idle after fire");
        xfer_pulse = 1'b1; cyc(1); xfer_pulse = 1'b0;
        cyc(48);
        chk(wdt_fire, 1'b1, "R8 xfer restart fires at 16*N");
        seen = 1'b0;
        for (int k = 0; k < 5; k++) begin
            xfer_pulse = 1'b1; cyc(1); xfer_pulse = 1'b0;
            for (int i = 0; i < 39; i++) begin
                cyc(1);
                if (wdt_fire) seen = 1'b1;
            end
        end
        chk(seen, 1'b0, "R9 xfer pulses keep watchdog quiet");
        wdata = 8'd0; wdt_we = 1'b1; cyc(1); wdt_we = 1'b0;
        xfer_pulse = 1'b1; cyc(1); xfer_pulse = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 300; i++) begin
            cyc(1);
            if (wdt_fire) seen = 1'b1;
        end
        chk(seen, 1'b0, "R9 reload 0 disables watchdog");
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_hth();
        t_sel();
        t_gen();
        t_restart();
        t_wdt();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule